// File: doc/BRIEF.md
# Multi-Bank GPIO Register Block

This block gives software control over several banks of 32 general-purpose pins through a flat, word-addressed register space. Each bank keeps a direction word and an output data word. Each pin drives two signals: an output-enable, which is active when the pin is an output, and the output level.

Software can change individual output bits without a read-modify-write sequence. A write to a bank's set word raises the output bits where the mask holds ones. A write to its clear word lowers them. All other bits keep their values. The pin levels enter through a two-flop synchronizer, and the bank's input word reports the synchronized level. This holds for pins that the block itself is driving, so software can read back the actual pad level. Because of the synchronizer, a read issued right after a write can still return the old level.

Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_multibank`

## Requirements
- R1: After reset, every direction bit is 1 (input), every output data bit is 0, and every pin_oe and pin_out bit is 0.
- R2: A write to a bank's direction word (bank base + 0x0) replaces it. A direction bit of 1 makes the pin an input (pin_oe bit 0), and a bit of 0 makes it an output (pin_oe bit 1). The word reads back as written.
- R3: A write to a bank's output data word (bank base + 0x4) replaces all 32 output bits. pin_out follows from the next cycle, and the word reads back as written.
- R4: A write to a bank's set word (bank base + 0x8) sets the output bits where the written mask is 1 and leaves the other bits unchanged.
- R5: A write to a bank's clear word (bank base + 0xC) clears the output bits where the written mask is 1 and leaves the other bits unchanged.
- R6: A read of the set word or the clear word returns the bank's current output data word.
- R7: The input word (bank base + 0x10) returns the pin level sampled through two flip-flops. A level applied before clock edge k is visible after edge k+1 but not after edge k. This holds whatever the pin's direction.
- R8: Bank k has its base at byte address 0x10 + 0x28*k. Bank pin j is bit j of the word and pin 32*k+j of the pin vectors. Address bits [1:0] are ignored. A write to one bank never changes another bank.
- R9: An address outside every bank's five data words is unmapped. This covers 0x00-0x0F, bank offsets 0x14-0x27 and everything above the last bank. A write to an unmapped address changes no register or pin, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (8) | Byte address for reads and writes |
| wdata | input | 32 | Write data or mask |
| rdata | output | 32 | Read data for addr, combinational |
| pin_in | input | NUM_BANKS*32 (160) | Asynchronous pin levels |
| pin_oe | output | NUM_BANKS*32 (160) | Output enable per pin, 1 = drive |
| pin_out | output | NUM_BANKS*32 (160) | Output level per pin |

## Verification
The bench sweeps every word address in the 8-bit space against an arithmetic model of all five banks.

Unmapped words, including the interrupt-area gap inside each bank, must read zero and must absorb all-ones writes. A decoder with a stride or base error would instead alter a neighbouring bank or return stale data.

Set and clear masks are applied over existing patterns that overlap the mask only partly. A design that wrote the mask through, or inverted the wrong operand, would then show the wrong bits on pin_out.

The input word is sampled one edge and two edges after a pin change. A synchronizer that was one stage short or one stage long would show the new level too early or too late. Driven output pins are included, to catch a read path that returns the output register instead of the pad.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GPIO_W = 32;

    // Word selected inside a bank's register window
    typedef enum logic [2:0] {
        WSEL_DIR  = 3'd0,
        WSEL_OUT  = 3'd1,
        WSEL_SET  = 3'd2,
        WSEL_CLR  = 3'd3,
        WSEL_IN   = 3'd4,
        WSEL_NONE = 3'd7
    } wsel_e;

    // Registered state of one bank
    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] dout;
    } bank_state_t;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_BANKS = 5,
    parameter int BASE_OFF  = 'h10,
    parameter int STRIDE    = 'h28,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [BANK_W-1:0] bank,
    output wsel_e             wsel
);

    localparam int DATA_WORDS = 5;

    logic [31:0] word_addr;

    always_comb begin
        word_addr = 32'({addr[ADDR_W-1:2], 2'b00});
        hit       = 1'b0;
        bank      = '0;
        wsel      = WSEL_NONE;
        for (int b = 0; b < NUM_BANKS; b++) begin
            int base_b;
            int rel;
            base_b = BASE_OFF + b * STRIDE;
            rel    = int'(word_addr) - base_b;
            if (rel >= 0 && rel < DATA_WORDS * 4) begin
                hit  = 1'b1;
                bank = BANK_W'(b);
                wsel = wsel_e'(3'(rel / 4));
            end
        end
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  wsel_e             wsel,
    input  logic [GPIO_W-1:0] wdata,
    input  logic [GPIO_W-1:0] pins,
    output logic [GPIO_W-1:0] dir,
    output logic [GPIO_W-1:0] dout,
    output logic [GPIO_W-1:0] din
);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            unique case (wsel)
                WSEL_DIR: st_d.dir  = wdata;
                WSEL_OUT: st_d.dout = wdata;
                WSEL_SET: st_d.dout = st_q.dout | wdata;
                WSEL_CLR: st_d.dout = st_q.dout & ~wdata;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir  <= '1;
            st_q.dout <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    gpio_sync #(
        .WIDTH  (GPIO_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (din)
    );

    assign dir  = st_q.dir;
    assign dout = st_q.dout;

endmodule

// File: rtl/gpio_multibank.sv
module gpio_multibank
    import gpio_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_BANKS   = 5,
    parameter int BASE_OFF    = 'h10,
    parameter int STRIDE      = 'h28,
    parameter int SYNC_STAGES = 2,
    localparam int PINS       = NUM_BANKS * GPIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out
);

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic              dec_hit;
    logic [BANK_W-1:0] dec_bank;
    wsel_e             dec_wsel;

    logic [NUM_BANKS-1:0][GPIO_W-1:0] bank_dir, bank_dout, bank_din;

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_BANKS (NUM_BANKS),
        .BASE_OFF  (BASE_OFF),
        .STRIDE    (STRIDE)
    ) u_dec (
        .addr (addr),
        .hit  (dec_hit),
        .bank (dec_bank),
        .wsel (dec_wsel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = wr_en && dec_hit && (dec_bank == BANK_W'(b));

        gpio_bank #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (sel),
            .wsel   (dec_wsel),
            .wdata  (wdata),
            .pins   (pin_in[b*GPIO_W +: GPIO_W]),
            .dir    (bank_dir[b]),
            .dout   (bank_dout[b]),
            .din    (bank_din[b])
        );

        assign pin_oe[b*GPIO_W +: GPIO_W]  = ~bank_dir[b];
        assign pin_out[b*GPIO_W +: GPIO_W] = bank_dout[b];
    end

    always_comb begin
        rdata = '0;
        if (dec_hit) begin
            unique case (dec_wsel)
                WSEL_DIR:           rdata = bank_dir[dec_bank];
                WSEL_OUT, WSEL_SET,
                WSEL_CLR:           rdata = bank_dout[dec_bank];
                WSEL_IN:            rdata = bank_din[dec_bank];
                default:            rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_multibank_chk.sv
module gpio_multibank_chk #(
    parameter int ADDR_W   = 8,
    parameter int PINS     = 160,
    parameter int BASE_OFF = 'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [PINS-1:0]   pin_in,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pin_out
);

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE_OFF);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE_OFF + 8);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(BASE_OFF + 12);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(BASE_OFF + 16);
    localparam logic [ADDR_W-1:0] A_LOW = ADDR_W'(BASE_OFF);

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    oe_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_oe));

    // R2
    dir_write_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DIR) |=> pin_oe[31:0] == ~$past(wdata));

    // R4
    set_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SET) |=> (pin_out[31:0] & $past(wdata)) == $past(wdata));

    // R5
    clr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CLR) |=> (pin_out[31:0] & $past(wdata)) == 32'h0);

    // R6
    set_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_SET || addr == A_CLR) |-> rdata == pin_out[31:0]);

    // R7
    in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_IN && since_rst >= 2'd2) |-> rdata == $past(pin_in[31:0], 2));

    // R9
    low_unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr < A_LOW) |-> rdata == 32'h0);

    // R9
    low_unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr < A_LOW) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_multibank gpio_multibank_chk #(
    .ADDR_W   (ADDR_W),
    .PINS     (PINS),
    .BASE_OFF (BASE_OFF)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_in  (pin_in),
    .pin_oe  (pin_oe),
    .pin_out (pin_out)
);

// File: tb/tb_gpio_multibank.sv
module tb_gpio_multibank;

    localparam int NB   = 5;
    localparam int PINS = NB * 32;
    localparam int BASE = 'h10;
    localparam int STR  = 'h28;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_oe, pin_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_dir [NB];
    logic [31:0] m_out [NB];

    always #10 clk = ~clk;

    gpio_multibank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr  = 8'(a);
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        addr = 8'(a);
        #1;
        check(req, rdata, exp);
    endtask

    function automatic logic [31:0] pat(input int b, input int k);
        return (32'h9E37_79B9 * (b + 1) + 32'h0101_0101 * k) ^ {b[7:0], k[7:0], 16'h5AC3};
    endfunction

    task automatic check_all(input string req);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            rd_check(req, BASE + b*STR + 0, m_dir[b]);
            rd_check(req, BASE + b*STR + 4, m_out[b]);
            check(req, pin_oe[b*32 +: 32], ~m_dir[b]);
            check(req, pin_out[b*32 +: 32], m_out[b]);
        end
    endtask

    function automatic bit mapped(input int a);
        for (int b = 0; b < NB; b++) begin
            if (a >= BASE + b*STR && a < BASE + b*STR + 20) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '1;
            m_out[b] = '0;
        end
        repeat (3) @(posedge clk);
        // R1: reset state, including before release
        @(negedge clk);
        check("R1", pin_oe[31:0], 32'h0);
        rst_n = 1'b1;
        check_all("R1");

        // R2, R3: direct writes per bank
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = pat(b, 1);
            m_out[b] = pat(b, 2);
            wr(BASE + b*STR + 0, m_dir[b]);
            wr(BASE + b*STR + 4, m_out[b]);
        end
        check_all("R2 R3");

        // R4, R5, R6: set/clear masks with partial overlap
        for (int k = 3; k < 8; k++) begin
            for (int b = 0; b < NB; b++) begin
                logic [31:0] s, c;
                s = pat(b, k);
                c = pat(b, k + 10) & ~s;
                wr(BASE + b*STR + 8, s);
                m_out[b] = m_out[b] | s;
                rd_check("R4 R6", BASE + b*STR + 8, m_out[b]);
                check("R4", pin_out[b*32 +: 32], m_out[b]);
                wr(BASE + b*STR + 12, c);
                m_out[b] = m_out[b] & ~c;
                rd_check("R5 R6", BASE + b*STR + 12, m_out[b]);
                check("R5", pin_out[b*32 +: 32], m_out[b]);
            end
        end
        check_all("R8");

        // R8: address low bits ignored
        wr(BASE + 2*STR + 8 + 3, 32'h0000_F000);
        m_out[2] = m_out[2] | 32'h0000_F000;
        check_all("R8");

        // R7: input synchronizer latency, any direction
        for (int k = 0; k < 4; k++) begin
            logic [PINS-1:0] old_v, new_v;
            old_v = pin_in;
            for (int b = 0; b < NB; b++) new_v[b*32 +: 32] = pat(b, 40 + k);
            @(negedge clk);
            pin_in = new_v;
            @(negedge clk);
            for (int b = 0; b < NB; b++)
                rd_check("R7", BASE + b*STR + 16, old_v[b*32 +: 32]);
            @(negedge clk);
            for (int b = 0; b < NB; b++)
                rd_check("R7", BASE + b*STR + 16, new_v[b*32 +: 32]);
        end
        // R7: driven pins still report the pad level
        wr(BASE + 0, 32'h0);
        m_dir[0] = 32'h0;
        @(negedge clk);
        pin_in[31:0] = ~m_out[0];
        repeat (2) @(negedge clk);
        rd_check("R7", BASE + 16, ~m_out[0]);

        // R9: sweep whole space; unmapped reads zero, writes ignored
        for (int a = 0; a < 256; a += 4) begin
            if (!mapped(a)) begin
                @(negedge clk);
                rd_check("R9", a, 32'h0);
                wr(a, 32'hFFFF_FFFF);
                wr(a, 32'h0);
            end
        end
        check_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule